// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links an A port and a B port through a data path that can run in either direction. Its width is divided into independent lanes of `LANE_W` bits, and each lane has its own set of controls. A lane can forward the live data from its source port to its destination port. It can also drive the destination port with a value that was captured earlier in a register belonging to the source port. Each port has one such capture register per lane, and each register is loaded by its own strobe. Loading does not depend on the lane's direction or enable settings.

Pins are modelled as three separate signals rather than as a real tri-state net:

- an external input value,
- an external-driver-present flag,
- an output value with an output enable.

For every bit a keeper records the resolved value on the wire. When nothing drives a pin, the pin reads back its last driven level instead of floating. Register strobes are edge-detected on the single system clock.

Top module: `regbus_xcvr`

## Requirements
- R1: Each lane (bits `l*LANE_W` upward) obeys only its own `oe_n`, `dir_ab`, `sel_ab`, `sel_ba`, `cap_a` and `cap_b` bits. The settings of another lane have no effect on it.
- R2: While a lane's `oe_n` bit is 1, that lane drives neither port: its `a_oe` and `b_oe` bits are 0 and its `a_out` and `b_out` bits read 0.
- R3: While a lane's `oe_n` bit is 0, only the destination port is driven. `dir_ab`=1 drives B (all `b_oe` lane bits are 1 and `a_oe` is 0). `dir_ab`=0 drives A (the reverse). The two enables of a bit are never 1 together.
- R4: With `sel_ab`=0, a lane that drives B outputs the live value of the A pin. With `sel_ba`=0, a lane that drives A outputs the live value of the B pin.
- R5: With `sel_ab`=1, a lane that drives B outputs the lane's A capture register.
- R6: With `sel_ba`=1, a lane that drives A outputs the lane's B capture register.
- R7: A register loads the resolved value of its own port's lane pins only on a 0-to-1 change of its strobe (`cap_a` for A, `cap_b` for B). Holding the strobe at 1 does not reload the register. The new value is visible on a driven output after the clock edge that samples the strobe rise.
- R8: A capture happens whatever the lane's `oe_n` and `dir_ab` settings are.
- R9: A pin bit whose external flag is 0 and which the block does not drive reads as the last value resolved on that wire. This holds both for live forwarding and for captures.
- R10: While `rst_n` is 0, the block drives no output. After reset, both capture registers and all keepers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| a_in | input | LANES*LANE_W | Value driven onto the A pins from outside |
| a_ext | input | LANES*LANE_W | 1 where an outside driver is active on an A pin |
| a_out | output | LANES*LANE_W | Value the block drives onto the A pins |
| a_oe | output | LANES*LANE_W | 1 where the block drives an A pin |
| b_in | input | LANES*LANE_W | Value driven onto the B pins from outside |
| b_ext | input | LANES*LANE_W | 1 where an outside driver is active on a B pin |
| b_out | output | LANES*LANE_W | Value the block drives onto the B pins |
| b_oe | output | LANES*LANE_W | 1 where the block drives a B pin |
| oe_n | input | LANES | Per-lane overriding output enable, active low |
| dir_ab | input | LANES | Per-lane direction: 1 = A to B, 0 = B to A |
| sel_ab | input | LANES | Per-lane B-side source: 0 = live A, 1 = A register |
| sel_ba | input | LANES | Per-lane A-side source: 0 = live B, 1 = B register |
| cap_a | input | LANES | Per-lane A register strobe, loads on a rise |
| cap_b | input | LANES | Per-lane B register strobe, loads on a rise |

## Verification
Live forwarding is tried in both directions with distinct byte patterns. In one step the two lanes point opposite ways, which separates true per-lane decoding from shared controls. Register paths are loaded while the lane is disabled and then read back after the live input has changed. This shows that the stored value is selected, and a strobe held high shows that only rising edges capture. Keeper behaviour is exposed by removing the external driver after a known value, both on a forwarded path and through a capture. A mixed select setting shows each lane choosing its own source.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     a_ext,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     a_oe,
  input  logic [W-1:0]     b_in,
  input  logic [W-1:0]     b_ext,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     b_oe,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir_ab,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [LANES-1:0] cap_a,
  input  logic [LANES-1:0] cap_b
);

  logic [W-1:0]     a_hold, b_hold, a_view, b_view, a_pin, b_pin, a_reg, b_reg;
  logic [LANES-1:0] cap_a_q, cap_b_q;

  // what each wire shows when the block itself is not driving it
  assign a_view = (a_ext & a_in) | (~a_ext & a_hold);
  assign b_view = (b_ext & b_in) | (~b_ext & b_hold);
  assign a_pin  = (a_oe & a_out) | (~a_oe & a_view);
  assign b_pin  = (b_oe & b_out) | (~b_oe & b_view);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LO = l * LANE_W;
    logic en;
    assign en = rst_n & ~oe_n[l];
    assign b_oe[LO +: LANE_W]  = {LANE_W{en &  dir_ab[l]}};
    assign a_oe[LO +: LANE_W]  = {LANE_W{en & ~dir_ab[l]}};
    assign b_out[LO +: LANE_W] = b_oe[LO +: LANE_W] &
                                 (sel_ab[l] ? a_reg[LO +: LANE_W] : a_view[LO +: LANE_W]);
    assign a_out[LO +: LANE_W] = a_oe[LO +: LANE_W] &
                                 (sel_ba[l] ? b_reg[LO +: LANE_W] : b_view[LO +: LANE_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_hold  <= '0;
      b_hold  <= '0;
      a_reg   <= '0;
      b_reg   <= '0;
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else begin
      a_hold  <= a_pin;
      b_hold  <= b_pin;
      cap_a_q <= cap_a;
      cap_b_q <= cap_b;
      for (int l = 0; l < LANES; l++) begin
        if (cap_a[l] && !cap_a_q[l]) a_reg[l*LANE_W +: LANE_W] <= a_pin[l*LANE_W +: LANE_W];
        if (cap_b[l] && !cap_b_q[l]) b_reg[l*LANE_W +: LANE_W] <= b_pin[l*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     a_out,
  input logic [W-1:0]     a_oe,
  input logic [W-1:0]     b_out,
  input logic [W-1:0]     b_oe,
  input logic [LANES-1:0] oe_n,
  input logic [LANES-1:0] dir_ab,
  input logic [LANES-1:0] sel_ab,
  input logic [LANES-1:0] sel_ba,
  input logic [LANES-1:0] cap_a,
  input logic [LANES-1:0] cap_b,
  input logic [W-1:0]     a_reg,
  input logic [W-1:0]     b_reg
);

  assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe & b_oe) == '0);

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (a_reg == '0 && b_reg == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    localparam int LO = l * LANE_W;

    assert_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[l] |-> (a_oe[LO +: LANE_W] == '0 && b_oe[LO +: LANE_W] == '0));

    assert_a_reg_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[l] && dir_ab[l] && sel_ab[l]) |-> b_out[LO +: LANE_W] == a_reg[LO +: LANE_W]);

    assert_b_reg_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n[l] && !dir_ab[l] && sel_ba[l]) |-> a_out[LO +: LANE_W] == b_reg[LO +: LANE_W]);

    assert_a_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_a[l] || $past(cap_a[l])) |=> $stable(a_reg[LO +: LANE_W]));

    assert_b_edge_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_b[l] || $past(cap_b[l])) |=> $stable(b_reg[LO +: LANE_W]));
  end

endmodule

bind regbus_xcvr regbus_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
  .oe_n(oe_n), .dir_ab(dir_ab), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .cap_a(cap_a), .cap_b(cap_b), .a_reg(a_reg), .b_reg(b_reg)
);

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a_in = '0, a_ext = '0, b_in = '0, b_ext = '0;
  logic [15:0] a_out, a_oe, b_out, b_oe;
  logic [1:0]  oe_n = 2'b11, dir_ab = '0, sel_ab = '0, sel_ba = '0, cap_a = '0, cap_b = '0;

  regbus_xcvr #(.LANES(2), .LANE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe), .oe_n(oe_n), .dir_ab(dir_ab),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_a(cap_a), .cap_b(cap_b)
  );

  always #4 clk = ~clk;

  typedef struct { string req; int which; logic [15:0] exp; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_out(input string req, input int which, input logic [15:0] exp);
    item_t it;
    it.req = req; it.which = which; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compares after the edge that follows each driver step
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = q.pop_front();
        case (it.which)
          0: got = a_out;
          1: got = a_oe;
          2: got = b_out;
          default: got = b_oe;
        endcase
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s sig%0d actual=%h expected=%h", it.req, it.which, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step();
    oe_n = 2'b00; dir_ab = 2'b11;
    expect_out("R10", 1, 16'h0000); expect_out("R10", 3, 16'h0000);
    step();
    rst_n = 1'b1; oe_n = 2'b11; dir_ab = 2'b00;
    expect_out("R10", 0, 16'h0000); expect_out("R10", 2, 16'h0000);
    expect_out("R2", 1, 16'h0000);  expect_out("R2", 3, 16'h0000);
    step();  // keeper starts at zero
    oe_n = 2'b10; dir_ab = 2'b01;
    expect_out("R10", 2, 16'h0000); expect_out("R3", 3, 16'h00FF);
    step();  // live A to B
    a_ext = 16'hFFFF; a_in = 16'h12A5;
    expect_out("R4", 2, 16'h00A5); expect_out("R3", 1, 16'h0000);
    step();  // driver leaves: keeper holds
    a_ext = 16'h0000; a_in = 16'h0000;
    expect_out("R9", 2, 16'h00A5);
    step();
    oe_n = 2'b11;
    expect_out("R2", 3, 16'h0000); expect_out("R2", 2, 16'h0000);
    step();  // lanes opposite ways
    oe_n = 2'b00; dir_ab = 2'b10;
    b_ext = 16'hFFFF; b_in = 16'h3C5A; a_ext = 16'hFF00; a_in = 16'h7700;
    expect_out("R1", 0, 16'h005A); expect_out("R1", 1, 16'h00FF);
    expect_out("R1", 2, 16'h7700); expect_out("R1", 3, 16'hFF00);
    step();  // capture A while disabled
    oe_n = 2'b11; dir_ab = 2'b00;
    a_ext = 16'hFFFF; a_in = 16'h9C3E; cap_a = 2'b11;
    expect_out("R8", 3, 16'h0000);
    step();  // strobe held high, live data changes
    a_in = 16'h1111; oe_n = 2'b00; dir_ab = 2'b11; sel_ab = 2'b11;
    expect_out("R5", 2, 16'h9C3E); expect_out("R7", 3, 16'hFFFF);
    step();
    cap_a = 2'b00;
    expect_out("R7", 2, 16'h9C3E);
    step();  // new rise reloads
    cap_a = 2'b01;
    expect_out("R7", 2, 16'h9C11);
    step();
    sel_ab = 2'b00; a_in = 16'h2468;
    expect_out("R4", 2, 16'h2468);
    step();  // capture B while disabled
    oe_n = 2'b11; b_ext = 16'hFFFF; b_in = 16'h4D61; cap_b = 2'b11;
    expect_out("R8", 1, 16'h0000);
    step();
    b_in = 16'h0000; dir_ab = 2'b00; oe_n = 2'b00; sel_ba = 2'b11;
    expect_out("R6", 0, 16'h4D61); expect_out("R6", 1, 16'hFFFF);
    step();  // per-lane select
    sel_ba = 2'b01;
    expect_out("R1", 0, 16'h0061);
    step();  // keeper value via capture
    cap_b = 2'b00; b_in = 16'hABCD; sel_ba = 2'b00;
    expect_out("R4", 0, 16'hABCD);
    step();
    b_ext = 16'h0000; b_in = 16'h0000;
    expect_out("R9", 0, 16'hABCD);
    step();
    cap_b = 2'b11; sel_ba = 2'b11;
    expect_out("R9", 0, 16'hABCD);
    step();
    oe_n = 2'b11;
    expect_out("R2", 1, 16'h0000);
    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule